// File: doc/BRIEF.md
# Operate-class micro-operation sequencer

This block carries out the operate class of instructions for a small word-oriented processor that keeps a 12-bit accumulator and a one-bit link. An upstream decoder recognises the operate opcode and passes the lower nine instruction bits (instruction bits 3 to 11) to this unit. It also passes the current accumulator, link, console switch word and program counter. Instruction bits are numbered from the most significant end: instruction bit n is `opr_bits[11-n]`.

Instruction bit 3 picks one of two groups. Group 1 clears and complements the accumulator and link, rotates the 13-bit link:accumulator pair, and increments that pair. Group 2 tests the accumulator and link for a conditional skip, clears the accumulator, merges in the switches, and can request a halt. Each micro-operation has its own bit, and the unit applies them in three fixed steps, one clock cycle per step.

A `start` pulse latches all operands. The results appear with a one-cycle `done` pulse and stay valid until the next start.

Top module: `opr_operate_unit`

## Requirements
- R1: `opr_bits[8]` (bit 3) = 0 selects group 1 and = 1 selects group 2. A group 1 operation always returns `skip` = 0, `halt` = 0 and `pc_out` = `pc_in`.
- R2: Group 1 step 1 works as follows. Bit 4 (`opr_bits[7]`) clears the accumulator, and bit 6 (`opr_bits[5]`) then complements it, so both bits together give all ones. Bit 5 (`opr_bits[6]`) clears the link, and bit 7 (`opr_bits[4]`) then complements it.
- R3: Group 1 step 2 rotates the 13-bit value {link, accumulator}, with the link as the most significant bit. The rotate code in bits 8..10 (`opr_bits[3:1]`, bit 8 most significant) selects the rotate: 2 = left by one, 3 = left by two, 4 = right by one, 5 = right by two.
- R4: Rotate codes 0, 1, 6 and 7 leave {link, accumulator} unchanged.
- R5: Group 1 step 3 adds one to the 13-bit {link, accumulator} when bit 11 (`opr_bits[0]`) is set, using the value after the rotate. The sum wraps modulo 2^13.
- R6: In group 2 the skip condition is the OR of three terms: bit 5 (`opr_bits[6]`) AND the accumulator sign bit, bit 6 (`opr_bits[5]`) AND accumulator equal to zero, and bit 7 (`opr_bits[4]`) AND link = 1. The test uses the accumulator value from before any clear.
- R7: Bit 8 (`opr_bits[3]`) inverts the skip condition. When the result is true, `skip` = 1 and `pc_out` = `pc_in` + 1 modulo 2^PC_W. Otherwise `pc_out` = `pc_in`.
- R8: In group 2, bit 4 (`opr_bits[7]`) first clears the accumulator, and then bit 9 (`opr_bits[2]`) ORs the switch word into it. The link is never changed in group 2.
- R9: In group 2, bit 10 (`opr_bits[1]`) sets `halt`. `halt` is 0 in every other case.
- R10: Suppose `start` is sampled high at a clock edge while `busy` = 0. Then `busy` is high after that edge and the next two edges. After the third following edge, `done` = 1 for exactly one cycle with `busy` = 0. A `start` that arrives while `busy` = 1 is ignored.
- R11: After a synchronous reset, `busy`, `done`, `skip` and `halt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latch operands and begin an operation |
| opr_bits | input | 9 | Instruction bits 3..11; bit n is opr_bits[11-n] |
| acc_in | input | DATA_W | Accumulator before the operation |
| link_in | input | 1 | Link before the operation |
| switches | input | DATA_W | Console switch word |
| pc_in | input | PC_W | Program counter (already pointing past the instruction) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results become valid |
| acc_out | output | DATA_W | Resulting accumulator |
| link_out | output | 1 | Resulting link |
| pc_out | output | PC_W | Program counter after any skip |
| skip | output | 1 | Skip request |
| halt | output | 1 | Halt request (clears run) |

## Verification
Every result is registered and appears after the third clock edge that follows the edge capturing `start`. That same edge raises `done`. The bench drives `start` on a falling edge and samples on each of the next falling edges. It requires `done` low after the first and second following edges and high after the third, and it compares accumulator, link, PC, skip and halt only in that cycle. The sweep covers every combination of the eight micro-operation bits in both groups against accumulator values that reach the sign, zero and all-ones cases, with both link values. The expected results come from a model that rotates by repeated arithmetic shifts. One run holds `start` high during an operation to show that the extra start changes neither the outputs nor the timing.

// File: rtl/opr_pkg.sv
// Shared types for the operate-class micro-operation sequencer.
// Assumes three micro-operation steps per instruction.
package opr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_S1   = 2'd1,
        PH_S2   = 2'd2,
        PH_S3   = 2'd3
    } phase_t;
endpackage

// File: rtl/opr_phase_ctrl.sv
// Step sequencer: accepts start only when idle, then walks S1, S2 and S3,
// one cycle each, and pulses done in the cycle after S3.
// Assumes a synchronous active-low reset.
module opr_phase_ctrl
    import opr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   accept,
    output logic   busy,
    output logic   done
);
    // start is honoured only in the idle phase
    assign accept = start && (phase == PH_IDLE);
    assign busy   = (phase != PH_IDLE);

    // phase advance and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            done <= (phase == PH_S3);
            case (phase)
                PH_IDLE: phase <= accept ? PH_S1 : PH_IDLE;
                PH_S1:   phase <= PH_S2;
                PH_S2:   phase <= PH_S3;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/opr_group1_unit.sv
// Group 1 step logic (combinational). Given the current phase, it returns
// the next {link, acc}: S1 clear/complement, S2 rotate, S3 increment.
// Assumes DATA_W >= 2 so that a two-place rotate is defined.
module opr_group1_unit
    import opr_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  phase_t            phase,
    input  logic [7:0]        ctl,      // instruction bits 4..11
    input  logic [DATA_W:0]   lac_in,
    output logic [DATA_W:0]   lac_out
);
    localparam int LW = DATA_W + 1;

    logic [DATA_W-1:0] acc_s1;
    logic              lnk_s1;
    logic [DATA_W:0]   rot;

    // step 1: clear then complement, accumulator and link separately
    always_comb begin
        acc_s1 = ctl[7] ? '0 : lac_in[DATA_W-1:0];
        acc_s1 = ctl[5] ? ~acc_s1 : acc_s1;
        lnk_s1 = ctl[6] ? 1'b0 : lac_in[DATA_W];
        lnk_s1 = ctl[4] ? ~lnk_s1 : lnk_s1;
    end

    // step 2: rotate selection on the 13-bit pair
    always_comb begin
        case (ctl[3:1])
            3'd2:    rot = {lac_in[LW-2:0], lac_in[LW-1]};
            3'd3:    rot = {lac_in[LW-3:0], lac_in[LW-1:LW-2]};
            3'd4:    rot = {lac_in[0], lac_in[LW-1:1]};
            3'd5:    rot = {lac_in[1:0], lac_in[LW-1:2]};
            default: rot = lac_in;
        endcase
    end

    // per-phase result selection
    always_comb begin
        case (phase)
            PH_S1:   lac_out = {lnk_s1, acc_s1};
            PH_S2:   lac_out = rot;
            PH_S3:   lac_out = ctl[0] ? lac_in + {{DATA_W{1'b0}}, 1'b1} : lac_in;
            default: lac_out = lac_in;
        endcase
    end
endmodule

// File: rtl/opr_group2_unit.sv
// Group 2 step logic (combinational). S1: skip test on the incoming acc,
// plus the clear. S2: OR in the switches. S3: halt request.
// Assumes the caller latches skip_set only in S1 and halt_set only in S3.
module opr_group2_unit
    import opr_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  phase_t             phase,
    input  logic [6:0]         ctl,      // instruction bits 4..10
    input  logic [DATA_W-1:0]  acc_in,
    input  logic               link_in,
    input  logic [DATA_W-1:0]  sw,
    output logic [DATA_W-1:0]  acc_out,
    output logic               skip_set,
    output logic               halt_set
);
    logic cond;

    // skip condition: sum of selected tests, sense flipped by bit 8
    always_comb begin
        cond     = (ctl[5] && acc_in[DATA_W-1])
                || (ctl[4] && (acc_in == '0))
                || (ctl[3] && link_in);
        skip_set = cond ^ ctl[2];
        halt_set = ctl[0];
    end

    // per-phase accumulator update
    always_comb begin
        case (phase)
            PH_S1:   acc_out = ctl[6] ? '0 : acc_in;
            PH_S2:   acc_out = ctl[1] ? (acc_in | sw) : acc_in;
            default: acc_out = acc_in;
        endcase
    end
endmodule

// File: rtl/opr_operate_unit.sv
// Operate-class micro-operation sequencer (top). It latches its operands on
// an accepted start, applies three group-specific steps and holds the
// results from done until the next start.
// Assumes the opcode is decoded upstream, so only instruction bits 3..11 arrive.
module opr_operate_unit
    import opr_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int PC_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [8:0]        opr_bits,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              link_in,
    input  logic [DATA_W-1:0] switches,
    input  logic [PC_W-1:0]   pc_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc_out,
    output logic              link_out,
    output logic [PC_W-1:0]   pc_out,
    output logic              skip,
    output logic              halt
);
    localparam int GRP_BIT = 8;

    phase_t            phase;
    logic              accept;
    logic [8:0]        ir_q;
    logic [DATA_W-1:0] ac_q;
    logic              link_q;
    logic [DATA_W-1:0] sw_q;
    logic [PC_W-1:0]   pc_q;
    logic              skip_q;
    logic              halt_q;
    logic [DATA_W:0]   g1_lac;
    logic [DATA_W-1:0] g2_ac;
    logic              g2_skip;
    logic              g2_halt;

    opr_phase_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .phase  (phase),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    opr_group1_unit #(.DATA_W(DATA_W)) u_g1 (
        .phase   (phase),
        .ctl     (ir_q[7:0]),
        .lac_in  ({link_q, ac_q}),
        .lac_out (g1_lac)
    );

    opr_group2_unit #(.DATA_W(DATA_W)) u_g2 (
        .phase    (phase),
        .ctl      (ir_q[7:1]),
        .acc_in   (ac_q),
        .link_in  (link_q),
        .sw       (sw_q),
        .acc_out  (g2_ac),
        .skip_set (g2_skip),
        .halt_set (g2_halt)
    );

    // operand capture and per-step state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q   <= '0;
            ac_q   <= '0;
            link_q <= 1'b0;
            sw_q   <= '0;
            pc_q   <= '0;
            skip_q <= 1'b0;
            halt_q <= 1'b0;
        end else if (accept) begin
            ir_q   <= opr_bits;
            ac_q   <= acc_in;
            link_q <= link_in;
            sw_q   <= switches;
            pc_q   <= pc_in;
            skip_q <= 1'b0;
            halt_q <= 1'b0;
        end else if (busy) begin
            if (ir_q[GRP_BIT]) begin
                ac_q <= g2_ac;
                if (phase == PH_S1) skip_q <= g2_skip;
                if (phase == PH_S3) halt_q <= g2_halt;
            end else begin
                {link_q, ac_q} <= g1_lac;
            end
        end
    end

    assign acc_out  = ac_q;
    assign link_out = link_q;
    assign skip     = skip_q;
    assign halt     = halt_q;
    assign pc_out   = pc_q + {{(PC_W-1){1'b0}}, skip_q};
endmodule

// File: rtl/opr_operate_unit_chk.sv
// Protocol and result checker for opr_operate_unit, attached by bind.
module opr_operate_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       skip,
    input logic       halt,
    input logic [8:0] ir_q
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##4 done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R1
    g1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ir_q[8]) |-> (!skip && !halt));
    // R9
    halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && halt) |-> (ir_q[8] && ir_q[1]));
    // R7
    no_sel_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ir_q[8] && (ir_q[6:3] == 4'b0000)) |-> !skip);
endmodule

bind opr_operate_unit opr_operate_unit_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .skip  (skip_q),
    .halt  (halt_q),
    .ir_q  (ir_q)
);

// File: tb/tb_opr_operate_unit.sv
`timescale 1ns/1ps
module tb_opr_operate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  opr_bits = '0;
    logic [11:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] switches = '0;
    logic [11:0] pc_in = '0;
    logic        busy, done, link_out, skip, halt;
    logic [11:0] acc_out, pc_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    opr_operate_unit #(.DATA_W(12), .PC_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opr_bits(opr_bits),
        .acc_in(acc_in), .link_in(link_in), .switches(switches), .pc_in(pc_in),
        .busy(busy), .done(done), .acc_out(acc_out), .link_out(link_out),
        .pc_out(pc_out), .skip(skip), .halt(halt)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected results from the requirements (rotation by repeated shifts)
    task automatic model(input logic [8:0] b, input int ac, input int lk, input int sw,
                         input int pc, output int eac, output int elk, output int esk,
                         output int eha, output int epc);
        int v; int code;
        bit [11:0] inb;
        inb = {3'b111, b};
        esk = 0; eha = 0;
        if (!inb[8]) begin
            if (inb[7]) ac = 0;
            if (inb[6]) lk = 0;
            if (inb[5]) ac = ac ^ 32'hFFF;
            if (inb[4]) lk = lk ^ 1;
            v = lk * 4096 + ac;
            code = int'(inb[3:1]);
            if (code == 2 || code == 3)
                for (int k = 0; k < code - 1; k++) v = ((v * 2) % 8192) + (v / 4096);
            if (code == 4 || code == 5)
                for (int k = 0; k < code - 3; k++) v = (v / 2) + (v % 2) * 4096;
            if (inb[0]) v = (v + 1) % 8192;
            eac = v % 4096; elk = v / 4096;
        end else begin
            int c;
            c = ((inb[6] && ac >= 2048) || (inb[5] && ac == 0) || (inb[4] && lk == 1)) ? 1 : 0;
            esk = c ^ int'(inb[3]);
            if (inb[7]) ac = 0;
            if (inb[2]) ac = ac | sw;
            eha = int'(inb[1]);
            eac = ac; elk = lk;
        end
        epc = (pc + esk) % 4096;
    endtask

    // one operation; alt_start keeps start high with other bits while busy
    task automatic run_op(input logic [8:0] b, input int ac, input int lk,
                          input int sw, input int pc, input bit alt_start);
        int eac, elk, esk, eha, epc;
        bit tmg;
        string t_acc, t_sk;
        model(b, ac, lk, sw, pc, eac, elk, esk, eha, epc);
        @(negedge clk);
        opr_bits = b; acc_in = 12'(ac); link_in = lk[0]; switches = 12'(sw); pc_in = 12'(pc);
        start = 1'b1;
        @(negedge clk);
        tmg = (busy === 1'b1) && (done === 1'b0);
        if (alt_start) begin
            opr_bits = ~b; acc_in = ~acc_in; link_in = ~link_in; pc_in = pc_in + 12'd7;
        end else start = 1'b0;
        @(negedge clk);
        tmg = tmg && (done === 1'b0) && (busy === 1'b1);
        @(negedge clk);
        start = 1'b0;
        tmg = tmg && (done === 1'b0) && (busy === 1'b1);
        @(negedge clk);
        tmg = tmg && (done === 1'b1) && (busy === 1'b0);
        chk(alt_start ? "R10 start-while-busy" : "R10", "done timing", int'(tmg), 1);
        if (!b[8]) begin
            if (b[0]) t_acc = "R5";
            else if (b[3:1] >= 3'd2 && b[3:1] <= 3'd5) t_acc = "R3";
            else if (b[3:1] != 3'd0) t_acc = "R4";
            else t_acc = "R2";
            chk(t_acc, "acc", int'(acc_out), eac);
            chk(t_acc, "link", int'(link_out), elk);
            chk("R1", "skip", int'(skip), 0);
            chk("R1", "halt", int'(halt), 0);
            chk("R1", "pc", int'(pc_out), epc);
        end else begin
            t_sk = b[3] ? "R7" : "R6";
            chk("R8", "acc", int'(acc_out), eac);
            chk("R8", "link", int'(link_out), elk);
            chk(t_sk, "skip", int'(skip), esk);
            chk("R7", "pc", int'(pc_out), epc);
            chk("R9", "halt", int'(halt), eha);
        end
        @(negedge clk);
        chk("R10", "single done pulse", int'(done), 0);
    endtask

    initial begin
        int acs[4] = '{0, 12'hFFF, 12'h5A3, 12'h800};
        repeat (3) @(negedge clk);
        chk("R11", "busy", int'(busy), 0);
        chk("R11", "done", int'(done), 0);
        chk("R11", "skip", int'(skip), 0);
        chk("R11", "halt", int'(halt), 0);
        rst_n = 1'b1;
        // group 1 sweep (R2 R3 R4 R5)
        for (int b = 0; b < 256; b++)
            for (int a = 0; a < 4; a++)
                for (int l = 0; l < 2; l++)
                    run_op({1'b0, 8'(b)}, acs[a], l, 12'h3C5, 12'h100 + b, 1'b0);
        // group 2 sweep (R6 R7 R8 R9); PC wrap at top of range
        for (int b = 0; b < 256; b++)
            for (int a = 0; a < 4; a++)
                for (int l = 0; l < 2; l++)
                    run_op({1'b1, 8'(b)}, acs[a], l, 12'h0F0 ^ (b * 3), (a == 1) ? 12'hFFF : 12'h200 + b, 1'b0);
        // R10: start held high while busy is ignored
        run_op(9'b0_1010_0101, 12'h123, 1, 0, 12'h010, 1'b1);
        run_op(9'b1_0110_0110, 12'h000, 0, 12'hABC, 12'h020, 1'b1);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule